// File: doc/BRIEF.md
# Capture/Compare Interval Timer

This block is an up-counting interval timer. A binary prescaler divides the core clock by a power of two, and each divided tick adds one to a 32-bit counter that wraps around. Software controls the counter through single-write task registers: start, stop, clear, and one capture task per channel. It reads results back through a flat word-addressed register port with a combinational read path.

Each capture/compare channel holds one 32-bit value. A capture loads that value from the counter. When the counter steps onto the value, the channel raises a sticky match flag. Per-channel shortcut bits let a match clear the counter, which gives periodic operation, or stop it, which gives a one-shot. Interrupt enables sit at bits 16 and up and are changed through separate set and clear addresses. A single level interrupt output reports any enabled match flag that is set. The channel count is a parameter: 4 in the standard build and 6 in the extended one.

Top module: `ccTimer`

## Requirements
- R1: The counter is 32 bits wide. It gains exactly one per tick, and after 0xFFFFFFFF it goes to 0.
- R2: The prescaler register at word address 0x23 (bits 3:0) keeps values 0 to 9. A larger written value is stored as 9. With setting p, ticks fall every 2^p clock cycles, and the first tick falls 2^p cycles after the edge that samples the start write.
- R3: A prescaler write made while the counter runs only changes the register. The tick rate keeps its old setting until a start issued from the stopped state loads the new one.
- R4: Writing a value with bit 0 set to address 0x00 starts counting, to 0x01 stops it, and to 0x02 clears it. A stopped counter holds its value. A clear sets the counter to 0, restarts the tick phase, and wins over a tick in the same cycle.
- R5: Writing a value with bit 0 set to address 0x08+n copies the counter value present in that cycle into channel n's value register. That register is at address 0x30+n and can also be written and read directly.
- R6: The match flag of channel n (address 0x10+n, bit 0) is set on the tick that moves the counter onto the channel value, and only on that tick. It stays set until a write with bit 0 clear. A write with bit 0 set leaves it unchanged, and a hardware set wins over a same-cycle clear write.
- R7: Bit n of the shortcut register (address 0x20) makes a channel n match clear the counter one cycle later. At prescaler 0 the counter then cycles through 0 to CC[n] with a period of CC[n]+1 cycles.
- R8: Bit 8+n of the shortcut register makes a channel n match stop the counter one cycle later. The counter then holds the value CC[n].
- R9: Writing ones to address 0x21 sets interrupt enable bits 16+n, and writing ones to address 0x22 clears them. Reading either address returns the enable bits at 16+n.
- R10: The interrupt output is high whenever at least one channel has both its match flag and its enable set, and low otherwise.
- R11: After reset the counter is stopped and at 0, all channel values are 0, flags, enables and shortcuts are 0, the prescaler reads 4, and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Write strobe for the register port |
| busAddr | input | 8 | Word address for read and write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| irq | output | 1 | Level interrupt from enabled match flags |

## Verification
The hardest case to reach is a match whose shortcut acts in the same cycle as a tick. The clear or stop must then beat the increment, so the counter never moves past the channel value. The bench reaches this by running at prescaler 0, where every cycle is a tick, with clear and stop shortcuts on small channel values. It then captures the counter after random delays and compares the result with the expected periodic and one-shot sequences. Prescaler hold-off is reached by rewriting the rate while the counter runs and checking captures against the old rate first and the new rate after a restart.

// File: rtl/ccTimerPkg.sv
package ccTimerPkg;
  localparam int CNT_W  = 32;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int PRESC_W = 4;
  localparam int PRESC_MAX = 9;
  localparam int DIV_W  = PRESC_MAX + 1;
  localparam int INT_BIT_BASE  = 16;
  localparam int STOP_BIT_BASE = 8;

  localparam logic [ADDR_W-1:0] ADDR_START     = 8'h00;
  localparam logic [ADDR_W-1:0] ADDR_STOP      = 8'h01;
  localparam logic [ADDR_W-1:0] ADDR_CLEAR     = 8'h02;
  localparam logic [ADDR_W-1:0] ADDR_CAPT_BASE = 8'h08;
  localparam logic [ADDR_W-1:0] ADDR_EVT_BASE  = 8'h10;
  localparam logic [ADDR_W-1:0] ADDR_SHORTS    = 8'h20;
  localparam logic [ADDR_W-1:0] ADDR_INTSET    = 8'h21;
  localparam logic [ADDR_W-1:0] ADDR_INTCLR    = 8'h22;
  localparam logic [ADDR_W-1:0] ADDR_PRESC     = 8'h23;
  localparam logic [ADDR_W-1:0] ADDR_CC_BASE   = 8'h30;

  typedef struct packed {
    logic                tickEn;
    logic                clearCnt;
    logic                loadPresc;
    logic [PRESC_W-1:0]  prescVal;
  } dpCtrl_t;
endpackage

// File: rtl/ccTimerDatapath.sv
module ccTimerDatapath
  import ccTimerPkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int RESET_PRESC = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  dpCtrl_t                        ctrl,
  input  logic [NUM_CH-1:0]              captStb,
  input  logic [NUM_CH-1:0]              ccWrStb,
  input  logic [CNT_W-1:0]               wrData,
  output logic [NUM_CH-1:0][CNT_W-1:0]   ccVals,
  output logic [NUM_CH-1:0]              cmpHit
);
  logic [PRESC_W-1:0] prescAct;
  logic [DIV_W-1:0]   divCnt;
  logic [DIV_W-1:0]   divLimit;
  logic               tick;
  logic [CNT_W-1:0]   count;
  logic [CNT_W-1:0]   countInc;

  assign divLimit = (DIV_W'(1) << prescAct) - DIV_W'(1);
  assign tick     = ctrl.tickEn && (divCnt == divLimit);
  assign countInc = count + CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescAct <= PRESC_W'(RESET_PRESC);
    end else if (ctrl.loadPresc) begin
      prescAct <= ctrl.prescVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (ctrl.loadPresc || ctrl.clearCnt) begin
      divCnt <= '0;
    end else if (ctrl.tickEn) begin
      divCnt <= tick ? '0 : divCnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (ctrl.clearCnt) begin
      count <= '0;
    end else if (tick) begin
      count <= countInc;
    end
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ccVals[n] <= '0;
      end else if (captStb[n]) begin
        ccVals[n] <= count;
      end else if (ccWrStb[n]) begin
        ccVals[n] <= wrData;
      end
    end

    assign cmpHit[n] = tick && !ctrl.clearCnt && (countInc == ccVals[n]);

    p_capture_r5: assert property (@(posedge clk) disable iff (!rstN)
      captStb[n] |=> (ccVals[n] == $past(count)));
  end

  p_wrap_r1: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !ctrl.clearCnt && (count == {CNT_W{1'b1}})) |=> (count == '0));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.tickEn && !ctrl.clearCnt) |=> $stable(count));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clearCnt |=> (count == '0));

  p_presc_held_r3: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.loadPresc |=> $stable(prescAct));

  p_hit_once_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cmpHit != '0) |=> ((cmpHit & $past(cmpHit)) == '0));
endmodule

// File: rtl/ccTimerCtrl.sv
module ccTimerCtrl
  import ccTimerPkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int RESET_PRESC = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           busWe,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic [DATA_W-1:0]              busWdata,
  input  logic [NUM_CH-1:0][CNT_W-1:0]   ccVals,
  input  logic [NUM_CH-1:0]              cmpHit,
  output dpCtrl_t                        ctrl,
  output logic [NUM_CH-1:0]              captStb,
  output logic [NUM_CH-1:0]              ccWrStb,
  output logic [DATA_W-1:0]              busRdata,
  output logic                           irq
);
  logic                running;
  logic [PRESC_W-1:0]  prescPend;
  logic [PRESC_W-1:0]  prescClamped;
  logic [NUM_CH-1:0]   shortClr;
  logic [NUM_CH-1:0]   shortStop;
  logic [NUM_CH-1:0]   intEn;
  logic [NUM_CH-1:0]   evtFlag;
  logic [NUM_CH-1:0]   evtClrWr;
  logic [NUM_CH-1:0]   cmpPulse;
  logic                startStb;
  logic                stopBus;
  logic                clearBus;
  logic                stopAll;
  logic                clearAll;

  assign startStb = busWe && (busAddr == ADDR_START) && busWdata[0];
  assign stopBus  = busWe && (busAddr == ADDR_STOP)  && busWdata[0];
  assign clearBus = busWe && (busAddr == ADDR_CLEAR) && busWdata[0];
  assign stopAll  = stopBus  || ((cmpPulse & shortStop) != '0);
  assign clearAll = clearBus || ((cmpPulse & shortClr) != '0);

  assign prescClamped = (busWdata > DATA_W'(PRESC_MAX)) ? PRESC_W'(PRESC_MAX)
                                                       : busWdata[PRESC_W-1:0];

  always_comb begin
    ctrl.tickEn    = running && !stopAll;
    ctrl.clearCnt  = clearAll;
    ctrl.loadPresc = startStb && !running && !stopAll;
    ctrl.prescVal  = prescPend;
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_dec
    assign captStb[n]  = busWe && (busAddr == ADDR_CAPT_BASE + ADDR_W'(n)) && busWdata[0];
    assign ccWrStb[n]  = busWe && (busAddr == ADDR_CC_BASE + ADDR_W'(n));
    assign evtClrWr[n] = busWe && (busAddr == ADDR_EVT_BASE + ADDR_W'(n)) && !busWdata[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
    end else if (stopAll) begin
      running <= 1'b0;
    end else if (startStb) begin
      running <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescPend <= PRESC_W'(RESET_PRESC);
      shortClr  <= '0;
      shortStop <= '0;
      intEn     <= '0;
    end else if (busWe) begin
      if (busAddr == ADDR_PRESC) prescPend <= prescClamped;
      if (busAddr == ADDR_SHORTS) begin
        shortClr  <= busWdata[NUM_CH-1:0];
        shortStop <= busWdata[STOP_BIT_BASE +: NUM_CH];
      end
      if (busAddr == ADDR_INTSET) intEn <= intEn | busWdata[INT_BIT_BASE +: NUM_CH];
      if (busAddr == ADDR_INTCLR) intEn <= intEn & ~busWdata[INT_BIT_BASE +: NUM_CH];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtFlag  <= '0;
      cmpPulse <= '0;
    end else begin
      evtFlag  <= cmpHit | (evtFlag & ~evtClrWr);
      cmpPulse <= cmpHit;
    end
  end

  assign irq = (evtFlag & intEn) != '0;

  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_PRESC) busRdata[PRESC_W-1:0] = prescPend;
    if (busAddr == ADDR_SHORTS) begin
      busRdata[NUM_CH-1:0] = shortClr;
      busRdata[STOP_BIT_BASE +: NUM_CH] = shortStop;
    end
    if (busAddr == ADDR_INTSET || busAddr == ADDR_INTCLR)
      busRdata[INT_BIT_BASE +: NUM_CH] = intEn;
    for (int n = 0; n < NUM_CH; n++) begin
      if (busAddr == ADDR_EVT_BASE + ADDR_W'(n)) busRdata[0] = evtFlag[n];
      if (busAddr == ADDR_CC_BASE + ADDR_W'(n))  busRdata = ccVals[n];
    end
  end

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(evtFlag) & ~$past(evtClrWr) & ~evtFlag) == '0));

  p_short_stop_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((cmpPulse & shortStop) != '0) |=> !running);

  p_irq_source_r10: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ((evtFlag != '0) && (intEn != '0)));

  p_presc_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    prescPend <= PRESC_W'(PRESC_MAX));
endmodule

// File: rtl/ccTimer.sv
module ccTimer
  import ccTimerPkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int RESET_PRESC = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWe,
  input  logic [7:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        irq
);
  dpCtrl_t                       dpCtrl;
  logic [NUM_CH-1:0]             captStb;
  logic [NUM_CH-1:0]             ccWrStb;
  logic [NUM_CH-1:0][CNT_W-1:0]  ccVals;
  logic [NUM_CH-1:0]             cmpHit;

  ccTimerCtrl #(.NUM_CH(NUM_CH), .RESET_PRESC(RESET_PRESC)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .ccVals(ccVals), .cmpHit(cmpHit), .ctrl(dpCtrl), .captStb(captStb),
    .ccWrStb(ccWrStb), .busRdata(busRdata), .irq(irq)
  );

  ccTimerDatapath #(.NUM_CH(NUM_CH), .RESET_PRESC(RESET_PRESC)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(dpCtrl), .captStb(captStb), .ccWrStb(ccWrStb),
    .wrData(busWdata), .ccVals(ccVals), .cmpHit(cmpHit)
  );
endmodule

// File: tb/ccTimer_tb.sv
module ccTimer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;
  int          total = 0;
  int          bad = 0;

  ccTimer u_dut (.clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
                 .busWdata(busWdata), .busRdata(busRdata), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] expFree(int unsigned k, int unsigned p);
    return 32'(k >> p);
  endfunction

  function automatic logic [31:0] expPeriodic(int unsigned k, int unsigned c);
    return 32'(k % (c + 1));
  endfunction

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    busAddr = a;
    #1;
    v = busRdata;
  endtask

  task automatic idle(int unsigned k);
    for (int i = 0; i < int'(k); i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5eed1));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    rd(8'h23, v); chk("R11 prescaler", v, 32'd4);
    rd(8'h30, v); chk("R11 cc0", v, 32'd0);
    rd(8'h10, v); chk("R11 event0", v, 32'd0);
    rd(8'h21, v); chk("R11 enables", v, 32'd0);
    rd(8'h20, v); chk("R11 shortcuts", v, 32'd0);
    chk("R11 irq", {31'b0, irq}, 32'd0);
    wr(8'h08, 1); rd(8'h30, v); chk("R11 counter zero via capture", v, 32'd0);

    // R2 clamp
    wr(8'h23, 32'd15); rd(8'h23, v); chk("R2 clamp", v, 32'd9);
    wr(8'h02, 1); wr(8'h00, 1); idle(600); wr(8'h09, 1);
    rd(8'h31, v); chk("R2 rate p9", v, expFree(600, 9));

    // R1 R2 random rates and capture delays
    for (int it = 0; it < 12; it++) begin
      int unsigned p, k, ch;
      p  = $urandom_range(0, 3);
      k  = $urandom_range(0, 60);
      ch = $urandom_range(0, 3);
      wr(8'h01, 1); wr(8'h23, p); wr(8'h02, 1); wr(8'h00, 1);
      idle(k);
      wr(8'h08 + 8'(ch), 1);
      rd(8'h30 + 8'(ch), v);
      chk("R1 R2 R5 capture at rate", v, expFree(k, p));
    end

    // R3 held prescaler
    wr(8'h01, 1); wr(8'h23, 0); wr(8'h02, 1); wr(8'h00, 1);
    wr(8'h23, 3); idle(8); wr(8'h0A, 1);
    rd(8'h32, v); chk("R3 old rate kept", v, 32'd9);
    rd(8'h23, v); chk("R3 pending readback", v, 32'd3);
    wr(8'h01, 1); wr(8'h02, 1); wr(8'h00, 1); idle(15); wr(8'h0A, 1);
    rd(8'h32, v); chk("R3 new rate after start", v, expFree(15, 3));

    // R4 stop holds, clear zeroes
    wr(8'h01, 1); wr(8'h23, 0); wr(8'h02, 1); wr(8'h00, 1);
    idle(4); wr(8'h01, 1); idle(10); wr(8'h0B, 1);
    rd(8'h33, v); chk("R4 stop holds", v, 32'd4);
    wr(8'h02, 1); wr(8'h0B, 1); rd(8'h33, v); chk("R4 clear while stopped", v, 32'd0);
    wr(8'h00, 1); idle(20); wr(8'h02, 1); idle(6); wr(8'h0B, 1);
    rd(8'h33, v); chk("R4 clear while running", v, 32'd6);
    wr(8'h00, 0); wr(8'h0B, 1); rd(8'h33, v); chk("R4 task bit0 clear ignored", v, 32'd8);

    // R6 compare event, R9 R10 interrupt
    wr(8'h01, 1); wr(8'h02, 1); wr(8'h30, 10); wr(8'h10, 0);
    wr(8'h00, 1);
    idle(9); rd(8'h10, v); chk("R6 no event before match", v, 32'd0);
    idle(1); rd(8'h10, v); chk("R6 event on match", v, 32'd1);
    chk("R10 irq masked", {31'b0, irq}, 32'd0);
    wr(8'h21, 32'h0001_0000);
    chk("R10 irq enabled", {31'b0, irq}, 32'd1);
    rd(8'h22, v); chk("R9 enable readback", v, 32'h0001_0000);
    wr(8'h22, 32'h0001_0000);
    chk("R9 clear enable", {31'b0, irq}, 32'd0);
    wr(8'h21, 32'h0001_0000);
    wr(8'h10, 1); rd(8'h10, v); chk("R6 write one ignored", v, 32'd1);
    wr(8'h10, 0); rd(8'h10, v); chk("R6 write zero clears", v, 32'd0);
    chk("R10 irq drops", {31'b0, irq}, 32'd0);
    idle(5); rd(8'h10, v); chk("R6 match only once", v, 32'd0);
    wr(8'h22, 32'h00FF_0000);

    // R7 periodic via clear shortcut
    wr(8'h01, 1); wr(8'h31, 5); wr(8'h20, 32'h0000_0002);
    for (int it = 0; it < 8; it++) begin
      int unsigned k;
      k = $urandom_range(0, 40);
      if (it == 0) k = 5;
      if (it == 1) k = 6;
      wr(8'h01, 1); wr(8'h02, 1); wr(8'h00, 1);
      idle(k); wr(8'h0A, 1);
      rd(8'h32, v); chk("R7 periodic count", v, expPeriodic(k, 5));
    end

    // R8 one-shot via stop shortcut
    wr(8'h01, 1); wr(8'h20, 32'h0000_0800); wr(8'h33, 7); wr(8'h13, 0);
    wr(8'h02, 1); wr(8'h00, 1); idle(30); wr(8'h08, 1);
    rd(8'h30, v); chk("R8 one-shot holds cc", v, 32'd7);
    rd(8'h13, v); chk("R8 event set", v, 32'd1);
    idle(20); wr(8'h08, 1); rd(8'h30, v); chk("R8 still stopped", v, 32'd7);

    summary();
  end
endmodule